// File: doc/BRIEF.md
# Three-Channel LED PWM Generator

This block turns three 12-bit duty-factor words into three pulse-width modulated enable signals for the red, green and blue LED drivers of a lighting fixture. One shared period counter steps once per system clock and repeats every 4095 clocks. At 2.5 MHz this gives a frame of about 610 Hz. Each channel is driven to its active level for the first D clocks of a frame, where D is that channel's duty word. Because the channels share one counter, every pulse begins on the same clock.

A control core streams new duty words into the block at any time over a valid/ready interface. The block never back-pressures: `duty_ready_o` is held high and a triplet is taken on every cycle in which `duty_valid_i` is high. Accepted words wait in a pending stage. They become the working duty values only when a new frame begins, so the frame in progress always completes with the values it started with. If several triplets arrive within one frame, the last one before the frame boundary is used.

A run enable starts and stops the counter. While the enable is low, all outputs rest at an idle level, which is the inactive level chosen by the polarity input. The polarity input also inverts the pulses while the block runs, so the block can drive either active-high or active-low driver enables.

Top module: `rgb_pwm_gen`

## Requirements
- R1: While `rst_ni` is low and after it is released with `enable_i` low and `active_low_i` low, all three outputs are 0 and `duty_ready_o` is 1.
- R2: While running, the frame is exactly 4095 clocks long. The shared count runs 0 to 4094 and returns to 0.
- R3: With a working duty D below 4095, a channel is at its active level for exactly D clocks of each frame. These are the first D clocks of the frame.
- R4: While `enable_i` is low, every output equals `active_low_i`, whatever duty words are presented.
- R5: The active level is 1 when `active_low_i` is 0 and 0 when it is 1. A change of `active_low_i` inverts the outputs combinationally, with no clock delay.
- R6: After `enable_i` is sampled high at a rising edge, the first frame begins in the clock that follows that edge, with the count at 0.
- R7: A duty triplet accepted during a frame has no effect on that frame. It becomes the working value at the next frame boundary.
- R8: A duty of 0 keeps a channel inactive for the whole frame. A duty of 4095 keeps it active for the whole frame.
- R9: In the first clock of every frame, each channel with a nonzero working duty is at its active level, so the rising edges of all channels line up.
- R10: Pulling `rst_ni` low while running forces the outputs to `active_low_i` at once, without waiting for a clock edge.
- R11: A triplet accepted while the block is disabled becomes the working value of the first frame after enabling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; low holds the outputs idle |
| active_low_i | input | 1 | Polarity select: 1 makes the outputs active-low |
| duty_valid_i | input | 1 | A duty triplet is offered this cycle |
| duty_ready_o | output | 1 | Always 1; the block accepts a triplet every cycle |
| duty_r_i | input | 12 | Red duty word |
| duty_g_i | input | 12 | Green duty word |
| duty_b_i | input | 12 | Blue duty word |
| pwm_r_o | output | 1 | Red driver enable |
| pwm_g_o | output | 1 | Green driver enable |
| pwm_b_o | output | 1 | Blue driver enable |

## Verification
The hardest case to reach from the ports is a duty word that arrives in the middle of a running frame. The check must show that the word stays out of that frame and is picked up exactly at the wrap from 4094 to 0. The bench reaches it by starting a frame at a known cycle, counting clocks from the enable, and offering a new red word 50 clocks into the frame. It then counts active clocks separately in the current frame and in the next one. It also samples the first clock of the second frame, which is active only if the frame length is exactly 4095.

// File: rtl/rgbpwm_pkg.sv
package rgbpwm_pkg;
  parameter int unsigned NCH = 3;

  function automatic int unsigned cnt_width(input int unsigned period);
    return (period > 1) ? $clog2(period) : 1;
  endfunction
endpackage

// File: rtl/rgbpwm_timebase.sv
module rgbpwm_timebase #(
  parameter int unsigned PERIOD = 4095,
  parameter int unsigned CNT_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= enable_i;
      if (!enable_i || !run_q || cnt_q == LAST) cnt_q <= '0;
      else                                     cnt_q <= cnt_q + 1'b1;
    end
  end

  // shadow duty registers refresh on this strobe: idle or last count
  assign load_o = !run_q || (cnt_q == LAST);
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_cnt_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && enable_i && cnt_q == LAST) |=> (cnt_q == '0));
  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && enable_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_idle_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (cnt_q == '0));
endmodule

// File: rtl/rgbpwm_shadow.sv
module rgbpwm_shadow #(
  parameter int unsigned DUTY_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              load_i,
  output logic [DUTY_W-1:0] active_o
);
  logic [DUTY_W-1:0] pend_q;
  logic [DUTY_W-1:0] pend_d;
  logic [DUTY_W-1:0] active_q;

  always_comb pend_d = valid_i ? duty_i : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      active_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (load_i) active_q <= pend_d;
    end
  end

  assign active_o = active_q;

  p_hold_mid_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(active_q));
endmodule

// File: rtl/rgbpwm_channel.sv
module rgbpwm_channel #(
  parameter int unsigned DUTY_W = 12,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              active_low_i,
  output logic              pwm_o
);
  localparam int unsigned CMP_W = (DUTY_W > CNT_W) ? DUTY_W : CNT_W;

  logic [CMP_W-1:0] cnt_ext;
  logic [CMP_W-1:0] duty_ext;
  logic             on;

  always_comb begin
    cnt_ext  = CMP_W'(cnt_i);
    duty_ext = CMP_W'(duty_i);
    on       = run_i && (cnt_ext < duty_ext);
    pwm_o    = on ^ active_low_i;
  end

  p_edge_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == '0 && duty_i != '0) |-> (pwm_o != active_low_i));
  p_zero_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == '0) |-> (pwm_o == active_low_i));
endmodule

// File: rtl/rgb_pwm_gen.sv
module rgb_pwm_gen #(
  parameter int unsigned DUTY_W = 12,
  parameter int unsigned PERIOD = 4095
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              active_low_i,
  input  logic              duty_valid_i,
  output logic              duty_ready_o,
  input  logic [DUTY_W-1:0] duty_r_i,
  input  logic [DUTY_W-1:0] duty_g_i,
  input  logic [DUTY_W-1:0] duty_b_i,
  output logic              pwm_r_o,
  output logic              pwm_g_o,
  output logic              pwm_b_o
);
  import rgbpwm_pkg::*;

  localparam int unsigned CNT_W = cnt_width(PERIOD);

  logic              run;
  logic [CNT_W-1:0]  cnt;
  logic              load;
  logic [DUTY_W-1:0] duty_in  [NCH];
  logic [DUTY_W-1:0] duty_act [NCH];
  logic [NCH-1:0]    pwm;

  assign duty_in[0] = duty_r_i;
  assign duty_in[1] = duty_g_i;
  assign duty_in[2] = duty_b_i;

  rgbpwm_timebase #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .run_o    (run),
    .cnt_o    (cnt),
    .load_o   (load)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    rgbpwm_shadow #(.DUTY_W(DUTY_W)) u_shadow (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (duty_valid_i),
      .duty_i   (duty_in[ch]),
      .load_i   (load),
      .active_o (duty_act[ch])
    );
    rgbpwm_channel #(.DUTY_W(DUTY_W), .CNT_W(CNT_W)) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .run_i        (run),
      .cnt_i        (cnt),
      .duty_i       (duty_act[ch]),
      .active_low_i (active_low_i),
      .pwm_o        (pwm[ch])
    );
  end

  assign duty_ready_o = 1'b1;
  assign pwm_r_o = pwm[0];
  assign pwm_g_o = pwm[1];
  assign pwm_b_o = pwm[2];

  p_idle_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (pwm == {NCH{active_low_i}}));
  p_reset_level_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (pwm == {NCH{active_low_i}}));
endmodule

// File: tb/rgb_pwm_gen_tb_top.sv
module rgb_pwm_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 4095;
  localparam int NVEC       = 5;
  // [36] active_low, [35:24] red, [23:12] green, [11:0] blue
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 12'd0,    12'd1,    12'd2048},
    {1'b0, 12'd4095, 12'd4094, 12'd3},
    {1'b1, 12'd100,  12'd0,    12'd4095},
    {1'b1, 12'd1,    12'd2,    12'd4094},
    {1'b0, 12'd2000, 12'd3000, 12'd1000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pol = 1'b0, vld = 1'b0;
  logic [11:0] dr = '0, dg = '0, db = '0;
  logic rdy, pr, pg, pb;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int cr, cg, cb;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_pwm_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .active_low_i(pol),
    .duty_valid_i(vld), .duty_ready_o(rdy),
    .duty_r_i(dr), .duty_g_i(dg), .duty_b_i(db),
    .pwm_r_o(pr), .pwm_g_o(pg), .pwm_b_o(pb)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cnt(input int d);
    return (d >= PERIOD) ? PERIOD : d;
  endfunction

  // sample n clocks at negedges from the current one, counting active clocks
  task automatic count_active(input int n);
    cr = 0; cg = 0; cb = 0;
    for (int i = 0; i < n; i++) begin
      if ((pr ^ pol) == 1'b1) cr++;
      if ((pg ^ pol) == 1'b1) cg++;
      if ((pb ^ pol) == 1'b1) cb++;
      @(negedge clk);
    end
  endtask

  task automatic push(input logic [11:0] r, input logic [11:0] g, input logic [11:0] b);
    dr = r; dg = g; db = b; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    // R1: reset state
    #(CLK_PERIOD*3 + 2);
    chk("R1 outputs in reset", {pr, pg, pb}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 outputs after reset", {pr, pg, pb}, 3'b000);
    chk("R1 ready high", rdy, 1);

    // R4: idle level ignores duty while disabled
    pol = 1'b1;
    push(12'd4095, 12'd4095, 12'd4095);
    @(negedge clk); @(negedge clk);
    chk("R4 idle high with active-low", {pr, pg, pb}, 3'b111);
    pol = 1'b0;
    #1;
    chk("R4 idle low with active-high", {pr, pg, pb}, 3'b000);
    @(negedge clk);

    // table of vectors; each triplet loaded while disabled (R11)
    for (int v = 0; v < NVEC; v++) begin
      en = 1'b0;
      @(negedge clk);
      push(VEC[v][35:24], VEC[v][23:12], VEC[v][11:0]);
      pol = VEC[v][36];
      @(negedge clk);
      chk("R4 idle level before enable", {pr, pg, pb}, {3{pol}});
      en = 1'b1;
      @(negedge clk);
      // first clock of the frame: R6/R9 alignment
      chk("R9 aligned start red",   (pr ^ pol), (VEC[v][35:24] != 0) ? 1 : 0);
      chk("R9 aligned start green", (pg ^ pol), (VEC[v][23:12] != 0) ? 1 : 0);
      chk("R9 aligned start blue",  (pb ^ pol), (VEC[v][11:0]  != 0) ? 1 : 0);
      count_active(PERIOD);
      chk("R3 R8 R11 R5 red count",   cr, exp_cnt(int'(VEC[v][35:24])));
      chk("R3 R8 R11 R5 green count", cg, exp_cnt(int'(VEC[v][23:12])));
      chk("R3 R8 R11 R5 blue count",  cb, exp_cnt(int'(VEC[v][11:0])));
    end

    // R7 and R2: mid-frame update applies at next frame only
    en = 1'b0; pol = 1'b0;
    @(negedge clk);
    push(12'd100, 12'd0, 12'd0);
    en = 1'b1;
    @(negedge clk);
    count_active(50);
    dr = 12'd3000; vld = 1'b1;
    if ((pr ^ pol) == 1'b1) cr++;
    @(negedge clk);
    vld = 1'b0;
    begin
      int keep;
      keep = cr;
      count_active(PERIOD - 51);
      cr = cr + keep;
    end
    chk("R7 current frame keeps old duty", cr, 100);
    chk("R2 frame restarts after 4095 clocks", pr, 1);
    count_active(PERIOD);
    chk("R7 next frame uses new duty", cr, 3000);

    // R5: polarity flips output combinationally while running
    push(12'd4095, 12'd0, 12'd0);
    count_active(PERIOD);
    chk("R5 active-high full duty", pr, 1);
    pol = 1'b1;
    #1;
    chk("R5 active-low full duty", pr, 0);
    chk("R5 active-low zero duty", pg, 1);
    pol = 1'b0;
    @(negedge clk);

    // R10: asynchronous reset while running
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R10 async reset forces idle", {pr, pg, pb}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule